// File: doc/BRIEF.md
# I2C Target Controller with Transmit Page and Receive FIFO

This block is the bus-facing part of an I2C target (slave) port with 7-bit addressing. It oversamples the raw SCL and SDA lines on the system clock, detects START and STOP conditions, and shifts in the address byte. It then checks the address against a small table of target addresses, each of which can be enabled or disabled on its own. When the address matches, the block acknowledges, records which table entry hit, and runs the data phase in the direction the R/W bit asks for.

Reads by the bus controller are served from an 8-entry transmit page that the host fills through a simple write strobe. Each START rewinds the page to its first entry. Writes from the bus controller land in an 8-entry receive FIFO that the host drains through a read strobe. When that FIFO is full, the next byte is refused with a NACK. The host sees level status bits and single-cycle interrupt pulses. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset `busy_o`, `bus_act_o` and `sda_oe_o` are low and `rx_empty_o` is high. A START (SDA falling while SCL is high) gives a one-cycle `start_irq_o` and sets `bus_act_o` and `busy_o`. A STOP (SDA rising while SCL is high) clears `bus_act_o`.
- R2: The first byte after a START is taken MSB first as a 7-bit address followed by R/W. It matches every enabled table entry `tgt_addr_i[7*i +: 7]` for which `tgt_en_i[i]` is 1, and the lowest matching index wins. On a match the block pulls SDA low in the ninth clock, pulses `amatch_irq_o`, and presents the winning index on `match_idx_o`.
- R3: On a match, `mode_o` takes the R/W bit: 1 means the block transmits and 0 means it receives.
- R4: If no enabled entry matches, SDA stays released for the rest of the transfer, so every byte sees NACK. No address-match interrupt is raised, and nothing enters the receive FIFO until the next START or STOP.
- R5: In transmit, bytes leave MSB first from consecutive transmit page entries. The first bit is placed on SDA while SCL is still low, before the first data clock.
- R6: After the eighth data bit the block releases SDA and samples the acknowledge on the ninth SCL rising edge. A high level there (NACK) pulses `nack_irq_o` and ends transmission until the next START.
- R7: Each transmitted byte pulses `txdone_irq_o` and clears `busy_o`. When the number of bytes sent since the last START equals a nonzero `tx_thresh_i`, `thresh_irq_o` pulses once.
- R8: Every START rewinds the transmit page, so the first byte of each read comes from page entry 0.
- R9: In receive, `busy_o` is high while a byte is being shifted in. Eight bits are taken MSB first on SCL rising edges, and an accepted byte is acknowledged and pushed into the FIFO. `rx_rdata_o` shows the oldest byte, and `rx_rd_i` removes it.
- R10: When the FIFO holds 8 bytes, `rx_full_o` is high and a further received byte is answered with NACK. That byte is dropped, and the stored bytes are left unchanged.
- R11: Host page writes (`tx_wr_i`) fill entries 0 to 7 in order and wrap back to 0. A write made while `busy_o` is high is ignored and does not advance the fill position.
- R12: A repeated START (a START with no STOP before it) begins a new address phase at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| tgt_addr_i | input | 7*NUM_ADDR | Target address table, entry i at bits 7*i+6:7*i |
| tgt_en_i | input | NUM_ADDR | Per-entry enable |
| tx_wr_i | input | 1 | Write strobe for the transmit page |
| tx_wdata_i | input | 8 | Byte written to the transmit page |
| tx_thresh_i | input | 4 | Transmit threshold in bytes (0 disables) |
| rx_rd_i | input | 1 | Removes the oldest byte from the receive FIFO |
| rx_rdata_o | output | 8 | Oldest byte in the receive FIFO |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| busy_o | output | 1 | Byte transfer in progress |
| bus_act_o | output | 1 | Between START and STOP |
| mode_o | output | 1 | 1 transmit, 0 receive |
| match_idx_o | output | 2 | Index of the matched address entry |
| start_irq_o | output | 1 | START pulse |
| amatch_irq_o | output | 1 | Address match pulse |
| txdone_irq_o | output | 1 | Byte transmitted pulse |
| nack_irq_o | output | 1 | NACK received pulse |
| thresh_irq_o | output | 1 | Threshold reached pulse |

## Verification
The assertions assume that the address table and its enables stay fixed while the bus is active. They also assume that each SCL phase lasts well beyond the synchronizer latency of about four clocks, and that the bus controller changes SDA only while SCL is low, apart from START and STOP. The stimulus keeps to this by driving SCL and SDA from bit-level tasks with 20-clock half periods. SDA always changes a few clocks after SCL falls, and the table and enables are set once before reset is released. Random transfers pick addresses from the table plus random values, with random direction, length and threshold. Directed sequences cover FIFO overflow, page rewind, repeated START and writes made while busy.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared constants and the protocol state type for the I2C target.
// Assumes byte-wide transfers and 7-bit addressing.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TXBIT,
        ST_TXACK,
        ST_TXNEXT,
        ST_RXBIT,
        ST_RXACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: brings SCL/SDA into the clock domain through a STAGES-deep flop
// chain and reports SCL edges and START/STOP conditions as one-cycle pulses.
// Assumes the lines idle high and each SCL phase outlasts STAGES+2 clocks.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q, scl_s, sda_s;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Synchronizer chain plus one history flop per line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~scl_q;
    assign scl_fall_o = ~scl_s & scl_q;
    assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
// Module: compares a received address with every enabled table entry in
// parallel and returns a hit flag plus the lowest matching index.
// Assumes the table is stable during the compare (purely combinational).
module i2c_tgt_addr_match #(
    parameter int NUM = 4,
    parameter int AW  = 7,
    parameter int IW  = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [NUM*AW-1:0] tbl_i,
    input  logic [NUM-1:0]    en_i,
    output logic              hit_o,
    output logic [IW-1:0]     idx_o
);
    logic [NUM-1:0] hit_vec;

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit_vec[g] = en_i[g] && (tbl_i[g*AW +: AW] == addr_i);
    end

    // Priority pick: the lowest index among the hits wins.
    always_comb begin
        idx_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx_o = IW'(i);
        end
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/i2c_tgt_fifo.sv
// Module: receive FIFO with show-ahead read data. Pushes when full and pops
// when empty are dropped. Assumes DEPTH >= 2.
module i2c_tgt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign full_o  = (cnt == (PW+1)'(DEPTH));
    assign empty_o = (cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem[rp];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/i2c_tgt_txpage.sv
// Module: transmit page. The host fills entries in order through a write
// port with a wrapping fill position, and the bus side reads any entry.
// Assumes the caller gates writes that must be ignored.
module i2c_tgt_txpage #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [W-1:0]  data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [W-1:0]  data_o,
    output logic [PW-1:0] wr_ptr_o
);
    logic [W-1:0] mem [DEPTH];

    // Entry write.
    always_ff @(posedge clk) begin
        if (wr_i) mem[wr_ptr_o] <= data_i;
    end

    // Fill position, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr_o <= '0;
        else if (wr_i) wr_ptr_o <= (wr_ptr_o == PW'(DEPTH-1)) ? '0 : wr_ptr_o + 1'b1;
    end

    assign data_o = mem[rd_idx_i];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Module: I2C target controller top. Runs the address and data phases on
// synchronized bus edges, drives SDA open-drain, serves reads from a transmit
// page and stores writes in a receive FIFO.
// Assumes 7-bit addressing, no clock stretching, and SCL phases of several
// clocks. The table and enables are stable while the bus is active.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter  int NUM_ADDR    = 4,
    parameter  int PAGE_DEPTH  = 8,
    parameter  int FIFO_DEPTH  = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int IDXW        = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1,
    localparam int PGW         = $clog2(PAGE_DEPTH),
    localparam int CNTW        = $clog2(PAGE_DEPTH + 1),
    localparam int BCW         = $clog2(BYTE_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [NUM_ADDR*ADDR_W-1:0] tgt_addr_i,
    input  logic [NUM_ADDR-1:0]        tgt_en_i,
    input  logic                       tx_wr_i,
    input  logic [BYTE_W-1:0]          tx_wdata_i,
    input  logic [CNTW-1:0]            tx_thresh_i,
    input  logic                       rx_rd_i,
    output logic [BYTE_W-1:0]          rx_rdata_o,
    output logic                       rx_empty_o,
    output logic                       rx_full_o,
    output logic                       busy_o,
    output logic                       bus_act_o,
    output logic                       mode_o,
    output logic [IDXW-1:0]            match_idx_o,
    output logic                       start_irq_o,
    output logic                       amatch_irq_o,
    output logic                       txdone_irq_o,
    output logic                       nack_irq_o,
    output logic                       thresh_irq_o
);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

    tgt_state_e        state;
    logic [BCW-1:0]    bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_oe, ack_on, rx_acc;
    logic [PGW-1:0]    rd_ptr;
    logic [CNTW-1:0]   sent, sent_nxt;

    logic sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic hit;
    logic [IDXW-1:0]   hit_idx;
    logic [BYTE_W-1:0] page_rdata;
    logic [PGW-1:0]    tx_wr_ptr;
    logic              rx_push, page_wr;
    logic [BYTE_W-1:0] rx_byte;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    i2c_tgt_addr_match #(.NUM(NUM_ADDR), .AW(ADDR_W), .IW(IDXW)) u_match (
        .addr_i (shreg[ADDR_W-1:0]),
        .tbl_i  (tgt_addr_i),
        .en_i   (tgt_en_i),
        .hit_o  (hit),
        .idx_o  (hit_idx)
    );

    assign page_wr = tx_wr_i && !busy_o;

    i2c_tgt_txpage #(.W(BYTE_W), .DEPTH(PAGE_DEPTH), .PW(PGW)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (page_wr),
        .data_i   (tx_wdata_i),
        .rd_idx_i (rd_ptr),
        .data_o   (page_rdata),
        .wr_ptr_o (tx_wr_ptr)
    );

    assign rx_byte = {shreg[BYTE_W-2:0], sda_s};
    assign rx_push = (state == ST_RXBIT) && scl_rise && (bitcnt == LAST_BIT);

    i2c_tgt_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_push),
        .data_i  (rx_byte),
        .pop_i   (rx_rd_i),
        .data_o  (rx_rdata_o),
        .empty_o (rx_empty_o),
        .full_o  (rx_full_o)
    );

    assign sent_nxt = sent + 1'b1;
    assign sda_oe_o = (state == ST_TXBIT) ? ~shreg[BYTE_W-1] : ack_oe;

    // Protocol sequencer: address phase, acknowledge slots, data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bitcnt       <= '0;
            shreg        <= '0;
            ack_oe       <= 1'b0;
            ack_on       <= 1'b0;
            rx_acc       <= 1'b0;
            rd_ptr       <= '0;
            sent         <= '0;
            busy_o       <= 1'b0;
            bus_act_o    <= 1'b0;
            mode_o       <= 1'b0;
            match_idx_o  <= '0;
            start_irq_o  <= 1'b0;
            amatch_irq_o <= 1'b0;
            txdone_irq_o <= 1'b0;
            nack_irq_o   <= 1'b0;
            thresh_irq_o <= 1'b0;
        end else begin
            start_irq_o  <= 1'b0;
            amatch_irq_o <= 1'b0;
            txdone_irq_o <= 1'b0;
            nack_irq_o   <= 1'b0;
            thresh_irq_o <= 1'b0;
            if (stop_c) begin
                state     <= ST_IDLE;
                bus_act_o <= 1'b0;
                busy_o    <= 1'b0;
                ack_oe    <= 1'b0;
            end else if (start_c) begin
                state       <= ST_ADDR;
                bus_act_o   <= 1'b1;
                busy_o      <= 1'b1;
                start_irq_o <= 1'b1;
                ack_oe      <= 1'b0;
                bitcnt      <= '0;
                rd_ptr      <= '0;
                sent        <= '0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                busy_o <= 1'b0;
                                if (hit) begin
                                    mode_o       <= sda_s;
                                    match_idx_o  <= hit_idx;
                                    amatch_irq_o <= 1'b1;
                                    ack_on       <= 1'b0;
                                    state        <= ST_AACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                ack_on <= 1'b1;
                                ack_oe <= 1'b1;
                            end else begin
                                ack_on <= 1'b0;
                                ack_oe <= 1'b0;
                                bitcnt <= '0;
                                if (mode_o) begin
                                    shreg  <= page_rdata;
                                    busy_o <= 1'b1;
                                    state  <= ST_TXBIT;
                                end else begin
                                    state <= ST_RXBIT;
                                end
                            end
                        end
                    end
                    ST_TXBIT: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                state <= ST_TXACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            txdone_irq_o <= 1'b1;
                            busy_o       <= 1'b0;
                            rd_ptr       <= (rd_ptr == PGW'(PAGE_DEPTH-1)) ? '0 : rd_ptr + 1'b1;
                            sent         <= sent_nxt;
                            if ((tx_thresh_i != '0) && (sent_nxt == tx_thresh_i))
                                thresh_irq_o <= 1'b1;
                            if (sda_s) begin
                                nack_irq_o <= 1'b1;
                                state      <= ST_SKIP;
                            end else begin
                                state <= ST_TXNEXT;
                            end
                        end
                    end
                    ST_TXNEXT: begin
                        if (scl_fall) begin
                            shreg  <= page_rdata;
                            bitcnt <= '0;
                            busy_o <= 1'b1;
                            state  <= ST_TXBIT;
                        end
                    end
                    ST_RXBIT: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == '0) busy_o <= 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                busy_o <= 1'b0;
                                rx_acc <= !rx_full_o;
                                ack_on <= 1'b0;
                                state  <= ST_RXACK;
                            end
                        end
                    end
                    ST_RXACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                ack_on <= 1'b1;
                                ack_oe <= rx_acc;
                            end else begin
                                ack_on <= 1'b0;
                                ack_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_RXBIT;
                            end
                        end
                    end
                    default: begin
                        ack_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_chk.sv
// Module: property checker for the I2C target, bound to the top module.
// Assumes the address enables are stable while the bus is active.
module i2c_tgt_chk #(
    parameter int NUM_ADDR = 4,
    parameter int IDXW     = 2,
    parameter int PGW      = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sda_oe,
    input logic                bus_act,
    input logic                busy,
    input logic                mode,
    input logic [IDXW-1:0]     match_idx,
    input logic [NUM_ADDR-1:0] tgt_en,
    input logic                start_irq,
    input logic                amatch_irq,
    input logic                txdone_irq,
    input logic                nack_irq,
    input logic                rx_full,
    input logic                rx_rd,
    input logic                tx_wr,
    input logic [PGW-1:0]      wr_ptr
);
    // R1
    start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |-> (bus_act && busy));

    // R4
    drive_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> bus_act);

    // R2
    match_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amatch_irq |-> tgt_en[match_idx]);

    // R6
    nack_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_irq |-> (txdone_irq && mode));

    // R10
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> rx_full);

    // R11
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_wr) |=> $stable(wr_ptr));
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk #(.NUM_ADDR(NUM_ADDR), .IDXW(IDXW), .PGW(PGW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe_o),
    .bus_act    (bus_act_o),
    .busy       (busy_o),
    .mode       (mode_o),
    .match_idx  (match_idx_o),
    .tgt_en     (tgt_en_i),
    .start_irq  (start_irq_o),
    .amatch_irq (amatch_irq_o),
    .txdone_irq (txdone_irq_o),
    .nack_irq   (nack_irq_o),
    .rx_full    (rx_full_o),
    .rx_rd      (rx_rd_i),
    .tx_wr      (tx_wr_i),
    .wr_ptr     (tx_wr_ptr)
);

// File: tb/i2c_tgt_ctrl_bench.sv
module i2c_tgt_ctrl_bench;
    localparam int H = 20;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe;
    wire         sda_line;
    logic [27:0] tbl = {7'h2A, 7'h51, 7'h51, 7'h2A};
    logic [3:0]  ten = 4'b1101;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_wd = '0;
    logic [3:0]  thr = '0;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_rdata;
    logic        rx_empty, rx_full, busy, bus_act, mode;
    logic [1:0]  midx;
    logic        s_irq, a_irq, d_irq, n_irq, t_irq;

    assign sda_line = sda_m & ~sda_oe;

    i2c_tgt_ctrl u_i2c_tgt_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .tgt_addr_i(tbl), .tgt_en_i(ten), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wd),
        .tx_thresh_i(thr), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata), .rx_empty_o(rx_empty),
        .rx_full_o(rx_full), .busy_o(busy), .bus_act_o(bus_act), .mode_o(mode),
        .match_idx_o(midx), .start_irq_o(s_irq), .amatch_irq_o(a_irq),
        .txdone_irq_o(d_irq), .nack_irq_o(n_irq), .thresh_irq_o(t_irq)
    );

    int n_chk = 0, n_fail = 0;
    int c_s = 0, c_a = 0, c_d = 0, c_n = 0, c_t = 0;
    logic [7:0] page [8];
    logic [7:0] rxq [$];
    logic mid_busy;

    // Interrupt pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (s_irq) c_s++;
        if (a_irq) c_a++;
        if (d_irq) c_d++;
        if (n_irq) c_n++;
        if (t_irq) c_t++;
    end

    function automatic int exp_idx(logic [6:0] a);
        for (int i = 0; i < 4; i++)
            if (ten[i] && tbl[i*7 +: 7] == a) return i;
        return -1;
    endfunction

    task automatic chk(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        wt(4); sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(logic b);
        wt(4); sda_m = b; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wt(4); sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H/2);
        b = sda_line; wt(H/2);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            put_bit(d[i]);
            if (i == 3) mid_busy = busy;
        end
        get_bit(ack);
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack, input logic inject);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
            if (inject && i == 4) begin
                tx_wr = 1'b1; tx_wd = ~page[0]; wt(1); tx_wr = 1'b0;
            end
        end
        put_bit(nack);
    endtask

    task automatic wr_page(logic [7:0] b, int slot);
        tx_wr = 1'b1; tx_wd = b; wt(1); tx_wr = 1'b0; wt(1);
        page[slot] = b;
    endtask

    task automatic pop_exp(string r, int exp);
        chk(r, rx_rdata, exp);
        rx_rd = 1'b1; wt(1); rx_rd = 1'b0; wt(1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic ack;
        logic [7:0] d;
        int s0, a0, d0, n0, t0;
        void'($urandom(32'h5EED_1234));
        wt(5); rst_n = 1'b1; wt(2);

        // R1 reset state
        chk("R1 busy reset", busy, 0);
        chk("R1 bus_act reset", bus_act, 0);
        chk("R1 sda_oe reset", sda_oe, 0);
        chk("R1 rx_empty reset", rx_empty, 1);

        // R11 fill the page in order
        for (int i = 0; i < 8; i++) wr_page(8'($urandom), i);

        // R1 / R2 / R3 / R9 directed write
        s0 = c_s; a0 = c_a;
        bus_start();
        chk("R1 start irq", c_s - s0, 1);
        chk("R1 bus_act after start", bus_act, 1);
        chk("R1 busy after start", busy, 1);
        write_byte({7'h2A, 1'b0}, ack);
        chk("R2 addr ack", ack, 0);
        chk("R2 match irq", c_a - a0, 1);
        chk("R2 priority idx", midx, 0);
        chk("R3 mode write", mode, 0);
        for (int k = 0; k < 3; k++) begin
            d = 8'($urandom);
            write_byte(d, ack);
            chk("R9 data ack", ack, 0);
            chk("R9 busy mid byte", mid_busy, 1);
            rxq.push_back(d);
        end
        bus_stop();
        chk("R1 bus_act after stop", bus_act, 0);
        while (rxq.size() > 0) pop_exp("R9 fifo order", int'(rxq.pop_front()));
        chk("R9 empty after drain", rx_empty, 1);

        // R4 no match
        a0 = c_a;
        bus_start();
        write_byte({7'h13, 1'b0}, ack);
        chk("R4 no-match nack", ack, 1);
        write_byte(8'h00, ack);
        chk("R4 data ignored nack", ack, 1);
        bus_stop();
        chk("R4 no match irq", c_a - a0, 0);
        chk("R4 fifo untouched", rx_empty, 1);

        // R2 disabled entry skipped
        bus_start();
        write_byte({7'h51, 1'b0}, ack);
        chk("R2 enabled dup ack", ack, 0);
        chk("R2 disabled skipped idx", midx, 2);
        bus_stop();

        // R5 / R6 / R7 / R11 directed read
        thr = 4'd3; d0 = c_d; n0 = c_n; t0 = c_t;
        bus_start();
        write_byte({7'h2A, 1'b1}, ack);
        chk("R3 mode read", mode, 1);
        for (int k = 0; k < 4; k++) begin
            read_byte(d, k == 3, k == 1);
            chk("R5 page data", d, page[k]);
        end
        bus_stop();
        chk("R7 txdone count", c_d - d0, 4);
        chk("R7 threshold once", c_t - t0, 1);
        chk("R6 nack irq", c_n - n0, 1);

        // R8 rewind and R11 ignored write
        bus_start();
        write_byte({7'h2A, 1'b1}, ack);
        read_byte(d, 1'b1, 1'b0);
        bus_stop();
        chk("R8 rewind to entry 0", d, page[0]);
        chk("R11 busy write ignored", d, page[0]);

        // R12 repeated start
        a0 = c_a;
        bus_start();
        write_byte({7'h2A, 1'b0}, ack);
        write_byte(8'hC3, ack);
        bus_start();
        write_byte({7'h2A, 1'b1}, ack);
        chk("R12 ack after rstart", ack, 0);
        chk("R12 mode after rstart", mode, 1);
        read_byte(d, 1'b1, 1'b0);
        chk("R12 read after rstart", d, page[0]);
        bus_stop();
        chk("R12 two matches", c_a - a0, 2);
        pop_exp("R12 written byte", 8'hC3);

        // R10 fifo full refusal
        bus_start();
        write_byte({7'h2A, 1'b0}, ack);
        for (int k = 0; k < 8; k++) begin
            d = 8'($urandom);
            write_byte(d, ack);
            chk("R10 accept until full", ack, 0);
            rxq.push_back(d);
        end
        chk("R10 full flag", rx_full, 1);
        write_byte(8'h5A, ack);
        chk("R10 refused nack", ack, 1);
        bus_stop();
        while (rxq.size() > 0) pop_exp("R10 contents kept", int'(rxq.pop_front()));
        chk("R10 empty after drain", rx_empty, 1);

        // Random transfers
        for (int t = 0; t < 20; t++) begin
            logic [6:0] a;
            logic rw;
            int n, e, th;
            case ($urandom_range(3, 0))
                0: a = 7'h2A;
                1: a = 7'h51;
                2: a = 7'h13;
                default: a = 7'($urandom);
            endcase
            rw = 1'($urandom);
            n  = $urandom_range(4, 1);
            th = $urandom_range(8, 0);
            e  = exp_idx(a);
            thr = 4'(th);
            d0 = c_d; t0 = c_t; n0 = c_n;
            bus_start();
            write_byte({a, rw}, ack);
            chk("R2 random addr ack", ack, (e >= 0) ? 0 : 1);
            if (e >= 0) begin
                chk("R2 random idx", midx, e);
                if (!rw) begin
                    for (int k = 0; k < n; k++) begin
                        d = 8'($urandom);
                        write_byte(d, ack);
                        chk("R9 random ack", ack, 0);
                        rxq.push_back(d);
                    end
                end else begin
                    for (int k = 0; k < n; k++) begin
                        read_byte(d, k == n - 1, 1'b0);
                        chk("R5 random page data", d, page[k]);
                    end
                end
            end
            bus_stop();
            if (e >= 0 && rw) begin
                chk("R7 random txdone", c_d - d0, n);
                chk("R7 random threshold", c_t - t0, (th != 0 && th <= n) ? 1 : 0);
                chk("R6 random nack", c_n - n0, 1);
            end
            while (rxq.size() > 0) pop_exp("R9 random fifo", int'(rxq.pop_front()));
        end

        // R11 refill wraps to entry 0 and all eight are served in order
        for (int i = 0; i < 8; i++) wr_page(8'($urandom), i);
        bus_start();
        write_byte({7'h2A, 1'b1}, ack);
        for (int k = 0; k < 8; k++) begin
            read_byte(d, k == 7, 1'b0);
            chk("R11 refill order", d, page[k]);
        end
        bus_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule